// File: doc/BRIEF.md
# Banked Interrupt Latch and Mask Controller

This block collects eleven event sources for a host and reports them on a single active-low interrupt pin. The sources are split into a low bank of eight and a high bank of three. A rising edge on any source sets a sticky latch bit. A separate host-detection power-on input sets its own latch bit at the top of the high bank. Each bank has a mask register, a live status view and a latch register. The host reaches these through a small address/data access port that stands in for a serial host bus.

A latch bit stays set until the host reads its bank. The read returns the latched value and clears it. An event that arrives in the same cycle as that clearing read is kept. Masks only decide which latched bits pull the interrupt pin low. Events are captured whether or not they are masked. The status views show the registered source levels. Three low-bank sources are not reported in the low status view.

Access requests are always accepted: there is no ready signal, and the port never applies back-pressure. Each read request produces exactly one response on `rd_valid_o` in the following cycle. The response has no ready either, so the host must take it in that cycle. Writes produce no response.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the masks read back as follows: low mask FFh, high mask 87h. Both latches read 00h, the low status reads 00h, the high status reads 80h, and `irq_n_o` is 1.
- R2: A 0-to-1 transition on a source sets its latch bit at the clock edge where the new level is first sampled. The bit positions are:
  - low bank: `evt_lo_i[k]` sets bit k;
  - high bank: `evt_hi_i[k]` sets bit k;
  - `hostdet_pwr_i` sets high-latch bit 7.
  A source held high does not set its bit again after it has been cleared.
- R3: A read request places its data on `rd_data_o` with `rd_valid_o`=1 in the cycle after the request. A read of the low latch (0Eh) or the high latch (0Fh) returns the pre-read value and clears that latch at the same edge. Address map:
  - masks: low 0Ah, high 0Bh;
  - status: low 0Ch, high 0Dh;
  - latches: low 0Eh, high 0Fh.
- R4: A rising edge that coincides with a clearing read of its bank is not returned by that read, but remains set afterwards.
- R5: `irq_n_o` is 0 exactly when some latch bit is set whose mask bit is 0. A mask bit of 1 blocks its source from the pin.
- R6: Mask bits do not affect capture. A masked source's edge is still latched and returned on read.
- R7: The low status view (0Ch) shows the registered low-bank levels, with bits 0, 1 and 4 always reading 0. In the high status view (0Dh), bits 2:0 show the high-bank levels. Its bit 7 is a power-on flag: it is 1 from reset until the first read of the high latch.
- R8: Writes to 0Ch–0Fh change no register. Reads of unmapped addresses return 00h.
- R9: The high mask stores only bits 2:0 and 7. All other bits read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_lo_i | input | 8 | Low-bank source levels |
| evt_hi_i | input | 3 | High-bank source levels |
| hostdet_pwr_i | input | 1 | Host-detection power-on indication |
| acc_valid_i | input | 1 | Access request, always accepted |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 8 | Register address |
| acc_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | Read response valid, one cycle after the request |
| rd_data_o | output | 8 | Read response data |
| irq_n_o | output | 1 | Interrupt, active low (open-drain intent) |

## Verification
The assertions take it that sources are synchronous to `clk` and change only between edges. They also take it that at most one access is presented per cycle. A read is expected to be a single-cycle `acc_valid_i` pulse with `acc_write_i` low. Under those conditions, every response is paired with exactly one prior request.

The stimulus changes inputs only on falling edges and holds each access for one cycle. It raises source bits one at a time. The exception is the deliberate case where an edge is driven together with a clearing read.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int DATA_W = 8;
  localparam logic [7:0] ADR_MASK_LO = 8'h0A;
  localparam logic [7:0] ADR_MASK_HI = 8'h0B;
  localparam logic [7:0] ADR_STAT_LO = 8'h0C;
  localparam logic [7:0] ADR_STAT_HI = 8'h0D;
  localparam logic [7:0] ADR_LAT_LO  = 8'h0E;
  localparam logic [7:0] ADR_LAT_HI  = 8'h0F;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK_LO, SEL_MASK_HI, SEL_STAT_LO,
    SEL_STAT_HI, SEL_LAT_LO, SEL_LAT_HI
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] lat_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign rise_o[k] = evt_i[k] & ~lvl_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[k] <= 1'b0;
        lat_q[k] <= 1'b0;
      end else begin
        lvl_q[k] <= evt_i[k];
        // a fresh edge outranks the read-clear
        lat_q[k] <= (lat_q[k] & ~clr_i) | rise_o[k];
      end
    end
  end

  assign level_o = lvl_q;
  assign latch_o = lat_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int          W     = 8,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] m_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    m_q <= WMASK;
    else if (we_i) m_q <= wdata_i & WMASK;
  end
  assign mask_o = m_q;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int          HI_SRC  = 3,
  parameter logic [7:0]  LO_SHOW = 8'hEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        evt_lo_i,
  input  logic [HI_SRC-1:0] evt_hi_i,
  input  logic              hostdet_pwr_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [7:0]        acc_addr_i,
  input  logic [7:0]        acc_wdata_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              irq_n_o
);
  localparam int PAD_W = DATA_W - 1 - HI_SRC;
  localparam logic [DATA_W-1:0] HI_WMASK = {1'b1, {PAD_W{1'b0}}, {HI_SRC{1'b1}}};

  reg_sel_e sel;
  logic     rd_req, wr_req;

  always_comb begin
    unique case (acc_addr_i)
      ADR_MASK_LO: sel = SEL_MASK_LO;
      ADR_MASK_HI: sel = SEL_MASK_HI;
      ADR_STAT_LO: sel = SEL_STAT_LO;
      ADR_STAT_HI: sel = SEL_STAT_HI;
      ADR_LAT_LO:  sel = SEL_LAT_LO;
      ADR_LAT_HI:  sel = SEL_LAT_HI;
      default:     sel = SEL_NONE;
    endcase
  end

  assign rd_req = acc_valid_i & ~acc_write_i;
  assign wr_req = acc_valid_i &  acc_write_i;

  logic clr_lo, clr_hi;
  assign clr_lo = rd_req && (sel == SEL_LAT_LO);
  assign clr_hi = rd_req && (sel == SEL_LAT_HI);

  logic [7:0]        lvl_lo, rise_lo, lat_lo;
  logic [HI_SRC-1:0] lvl_hi, rise_hi, lat_hi;
  logic [0:0]        lvl_pw, rise_pw, lat_pw;

  irq_edge_latch #(.W(8)) u_lo (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_lo_i), .clr_i(clr_lo),
    .level_o(lvl_lo), .rise_o(rise_lo), .latch_o(lat_lo));

  irq_edge_latch #(.W(HI_SRC)) u_hi (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_hi_i), .clr_i(clr_hi),
    .level_o(lvl_hi), .rise_o(rise_hi), .latch_o(lat_hi));

  irq_edge_latch #(.W(1)) u_pw (
    .clk(clk), .rst_n(rst_n), .evt_i(hostdet_pwr_i), .clr_i(clr_hi),
    .level_o(lvl_pw), .rise_o(rise_pw), .latch_o(lat_pw));

  logic [DATA_W-1:0] mask_lo, mask_hi;

  irq_mask_reg #(.W(DATA_W), .WMASK('1)) u_mlo (
    .clk(clk), .rst_n(rst_n), .we_i(wr_req && (sel == SEL_MASK_LO)),
    .wdata_i(acc_wdata_i), .mask_o(mask_lo));

  irq_mask_reg #(.W(DATA_W), .WMASK(HI_WMASK)) u_mhi (
    .clk(clk), .rst_n(rst_n), .we_i(wr_req && (sel == SEL_MASK_HI)),
    .wdata_i(acc_wdata_i), .mask_o(mask_hi));

  // power-on flag: set by reset, dropped on the first high-latch read
  logic pon_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pon_q <= 1'b1;
    else if (clr_hi) pon_q <= 1'b0;
  end

  logic [DATA_W-1:0] lat_hi_word, stat_hi_word, stat_lo_word;
  always_comb begin
    lat_hi_word = '0;
    lat_hi_word[HI_SRC-1:0] = lat_hi;
    lat_hi_word[DATA_W-1]   = lat_pw[0];
    stat_hi_word = '0;
    stat_hi_word[HI_SRC-1:0] = lvl_hi;
    stat_hi_word[DATA_W-1]   = pon_q;
    stat_lo_word = lvl_lo & LO_SHOW;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_MASK_LO: rd_mux = mask_lo;
      SEL_MASK_HI: rd_mux = mask_hi;
      SEL_STAT_LO: rd_mux = stat_lo_word;
      SEL_STAT_HI: rd_mux = stat_hi_word;
      SEL_LAT_LO:  rd_mux = lat_lo;
      SEL_LAT_HI:  rd_mux = lat_hi_word;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req;
      if (rd_req) rd_data_o <= rd_mux;
    end
  end

  assign irq_n_o = ~(|(lat_lo & ~mask_lo) | |(lat_hi_word & ~mask_hi));
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid_i,
  input logic       acc_write_i,
  input logic [7:0] acc_addr_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       irq_n_o,
  input logic [7:0] mask_lo,
  input logic [7:0] mask_hi,
  input logic [7:0] lat_lo,
  input logic [7:0] rise_lo
);
  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_write_i) |=> rd_valid_o);

  // R3
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid_i && !acc_write_i) |=> !rd_valid_o);

  // R3
  lat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_write_i && acc_addr_i == 8'h0E && rise_lo == 8'h00)
      |=> lat_lo == 8'h00);

  // R4
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_write_i && acc_addr_i == 8'h0E)
      |=> lat_lo == $past(rise_lo));

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_write_i && acc_addr_i[7:2] == 6'b000011)
      |=> ($stable(mask_lo) && $stable(mask_hi)
           && lat_lo == ($past(lat_lo) | $past(rise_lo))));

  // R7
  stat_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_write_i && acc_addr_i == 8'h0C)
      |=> (rd_data_o[0] == 1'b0 && rd_data_o[1] == 1'b0 && rd_data_o[4] == 1'b0));

  // R5
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lo == 8'hFF && mask_hi == 8'h87) |-> irq_n_o);

  // R9
  mask_hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hi & 8'h78) == 8'h00);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o),
  .mask_lo(mask_lo), .mask_hi(mask_hi), .lat_lo(lat_lo), .rise_lo(rise_lo));

// File: tb/irq_latch_ctrl_tb_top.sv
module irq_latch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_lo = '0;
  logic [2:0] evt_hi = '0;
  logic       hostdet = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_lo_i(evt_lo), .evt_hi_i(evt_hi),
    .hostdet_pwr_i(hostdet), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .irq_n_o(irq_n));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected response", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // called at a falling edge, returns at the next falling edge
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 8'h01, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n idle", {7'd0, irq_n}, 8'h01);
    rd(8'h0A, 8'hFF, "R1 mask lo");
    rd(8'h0B, 8'h87, "R1 mask hi");
    rd(8'h0C, 8'h00, "R1 status lo");
    rd(8'h0D, 8'h80, "R1 status hi");
    rd(8'h0E, 8'h00, "R1 latch lo");
    rd(8'h0F, 8'h00, "R1 latch hi");
    rd(8'h0D, 8'h00, "R7 power-on flag cleared by latch hi read");
    // R2 edge capture, R3 read-clear
    evt_lo[2] = 1'b1;
    @(negedge clk);
    rd(8'h0E, 8'h04, "R2 edge bit2 latched");
    rd(8'h0E, 8'h00, "R3 latch cleared, R2 held level not re-latched");
    rd(8'h0C, 8'h04, "R7 status lo live bit2");
    evt_lo[0] = 1'b1;
    @(negedge clk);
    rd(8'h0C, 8'h04, "R7 status lo bit0 hidden");
    rd(8'h0E, 8'h01, "R2 hidden source still latched");
    // R5/R6 masking
    evt_lo[5] = 1'b1;
    @(negedge clk);
    check("R5 masked edge keeps irq high", {7'd0, irq_n}, 8'h01);
    wr(8'h0A, 8'hDF);
    check("R5 unmasked latch drives irq low", {7'd0, irq_n}, 8'h00);
    rd(8'h0E, 8'h20, "R6 masked event captured");
    check("R5 irq released after clear", {7'd0, irq_n}, 8'h01);
    // R4 edge coincident with clearing read
    evt_lo[6] = 1'b1;
    rd(8'h0E, 8'h00, "R4 coincident edge not in read data");
    rd(8'h0E, 8'h40, "R4 coincident edge retained");
    // high bank
    evt_hi[0] = 1'b1;
    @(negedge clk);
    check("R5 high bank masked", {7'd0, irq_n}, 8'h01);
    wr(8'h0B, 8'h86);
    check("R5 high bank unmasked irq", {7'd0, irq_n}, 8'h00);
    rd(8'h0D, 8'h01, "R7 status hi live bit0");
    rd(8'h0F, 8'h01, "R2 high bank bit0 latched");
    hostdet = 1'b1;
    @(negedge clk);
    check("R5 bit7 masked", {7'd0, irq_n}, 8'h01);
    rd(8'h0F, 8'h80, "R2 host-detect power-on at bit7");
    // R8 read-only addresses and unmapped read
    evt_lo[7] = 1'b1;
    @(negedge clk);
    wr(8'h0E, 8'h00);
    wr(8'h0C, 8'hFF);
    wr(8'h0F, 8'hFF);
    rd(8'h0E, 8'h80, "R8 latch write ignored");
    rd(8'h0F, 8'h00, "R8 latch hi write ignored");
    rd(8'h05, 8'h00, "R8 unmapped read zero");
    rd(8'h0A, 8'hDF, "R8 mask lo untouched by ro writes");
    // R9 high mask width
    wr(8'h0B, 8'hFF);
    rd(8'h0B, 8'h87, "R9 mask hi stored bits");
    wr(8'h0B, 8'h78);
    rd(8'h0B, 8'h00, "R9 mask hi unused bits dropped");
    repeat (3) @(negedge clk);
    check("R3 all responses seen", exp_q.size()[7:0], 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule